// File: doc/BRIEF.md
# Edge-Triggered Delayed Pulse Generator

This block turns a rising edge on a single digital line into one output pulse that starts a set time after the edge. Time is counted in ticks of a time-base strobe, `tick_i`, which is a one-clock pulse from a divider elsewhere in the chip. After a qualifying edge, the block waits `delay_len_i` ticks and then holds `pulse_o` high for `pulse_len_i` ticks. With a 10 ms tick, the typical setting of 500 and 100 gives a 5 s wait and a 1 s pulse.

A cycle locks itself on as soon as it starts. Any further movement of the trigger line is ignored until the pulse has ended and the block is idle again. The start condition is a one-clock one-shot taken from the trigger line, so a trigger that simply stays high never starts a second cycle. Both length inputs may be changed at any time. The block copies them when a cycle starts, so each new cycle uses the values present at its own start. `busy_o` reports that a cycle is in progress.

Top module: `delayed_oneshot`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `pulse_o` and `busy_o` are 0. A trigger that is already high when reset is released does not start a cycle.
- R2: While idle, a clock edge at which `trig_i` is 1 and was 0 at the previous edge starts a cycle, and `busy_o` is 1 from that edge on.
- R3: A trigger held at 1, whether from before the start, through a whole cycle, or after it, never starts another cycle. A new cycle needs the trigger to be 0 at one edge and 1 at the next.
- R4: `pulse_o` rises at the clock edge that samples the N-th `tick_i` pulse after the start edge, where N is the latched delay length. A tick present on the start edge itself is not counted.
- R5: `pulse_o` stays high until the edge that samples the M-th tick after it rose, where M is the latched pulse length. At that edge `pulse_o` and `busy_o` both fall.
- R6: While `busy_o` is 1, changes on `trig_i` have no effect on the timing of `pulse_o` or `busy_o`.
- R7: A rising trigger edge at the same clock edge at which the cycle ends is ignored, and `busy_o` is 0 after that edge.
- R8: Both lengths are sampled at the start edge. Changing them during a cycle does not alter that cycle, and the next cycle uses the new values.
- R9: A delay or pulse length of 0 behaves as a length of 1 tick.
- R10: `pulse_o` is high only while `busy_o` is high, and `pulse_o` changes only at an edge where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Time-base strobe, one clock wide per tick |
| trig_i | input | 1 | Trigger line, already synchronous to `clk` |
| delay_len_i | input | CNT_W | Delay length in ticks (0 is taken as 1) |
| pulse_len_i | input | CNT_W | Pulse length in ticks (0 is taken as 1) |
| pulse_o | output | 1 | Delayed output pulse, registered |
| busy_o | output | 1 | A cycle is in progress, registered |

## Verification
Single clean edges with a quiet trigger show that the delay and pulse counts land on the right tick. Running them with a tick every clock, every few clocks and at random spacing separates counting ticks from counting clocks. A trigger held high through and past a cycle, and a trigger that toggles at random during a cycle, show that the block is driven by the one-shot and not by the input level, and that it is locked during a cycle. Directed cases cover an edge that lands exactly on the ending edge, length changes made during a cycle, zero lengths, and the full 500/100 setting.

// File: rtl/delayed_oneshot_pkg.sv
package delayed_oneshot_pkg;

  // Phases of one trigger-to-pulse cycle
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_FIRE = 2'd2
  } phase_t;

endpackage

// File: rtl/dos_edge_detect.sv
// One-clock rise strobe from a synchronous level. The history register
// resets to IDLE_LEVEL so that a line already high at reset is not an edge.
module dos_edge_detect #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= IDLE_LEVEL;
    else     level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/dos_len_latch.sv
// Captures a length at cycle start; zero is promoted to one tick.
module dos_len_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] len_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)         len_o <= ONE;
    else if (load_i) len_o <= (len_i == '0) ? ONE : len_i;
  end

endmodule

// File: rtl/dos_tick_counter.sv
// Counts enabled ticks up to a limit; done is asserted with the last tick.
module dos_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step   = en_i & tick_i;
  assign done_o = step & (cnt_q == limit_i - ONE);

  always_ff @(posedge clk) begin
    if (rst || clr_i || done_o) cnt_q <= '0;
    else if (step)              cnt_q <= cnt_q + ONE;
  end

endmodule

// File: rtl/dos_phase_ctrl.sv
// Sequencer: idle -> wait -> fire -> idle. Outputs are registered.
module dos_phase_ctrl
  import delayed_oneshot_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   rise_i,
  input  logic   done_i,
  output phase_t phase_o,
  output logic   load_o,
  output logic   pulse_o,
  output logic   busy_o
);

  phase_t phase_q;

  assign phase_o = phase_q;
  assign load_o  = (phase_q == PH_IDLE) & rise_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pulse_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (rise_i) begin
          phase_q <= PH_WAIT;
          busy_o  <= 1'b1;
        end
        PH_WAIT: if (done_i) begin
          phase_q <= PH_FIRE;
          pulse_o <= 1'b1;
        end
        PH_FIRE: if (done_i) begin
          phase_q <= PH_IDLE;
          pulse_o <= 1'b0;
          busy_o  <= 1'b0;
        end
        default: begin
          phase_q <= PH_IDLE;
          pulse_o <= 1'b0;
          busy_o  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/delayed_oneshot.sv
module delayed_oneshot
  import delayed_oneshot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] delay_len_i,
  input  logic [CNT_W-1:0] pulse_len_i,
  output logic             pulse_o,
  output logic             busy_o
);

  localparam int NUM_LEN = 2;  // index 0: delay, 1: pulse

  logic                  rise;
  logic                  load;
  logic                  done;
  phase_t                phase;
  logic [CNT_W-1:0]      len_in  [NUM_LEN];
  logic [CNT_W-1:0]      len_lat [NUM_LEN];
  logic [CNT_W-1:0]      limit;

  assign len_in[0] = delay_len_i;
  assign len_in[1] = pulse_len_i;

  dos_edge_detect #(.IDLE_LEVEL(1'b1)) edge_i (
    .clk     (clk),
    .rst     (rst),
    .level_i (trig_i),
    .rise_o  (rise)
  );

  for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
    dos_len_latch #(.CNT_W(CNT_W)) latch_i (
      .clk    (clk),
      .rst    (rst),
      .load_i (load),
      .len_i  (len_in[g]),
      .len_o  (len_lat[g])
    );
  end

  assign limit = (phase == PH_FIRE) ? len_lat[1] : len_lat[0];

  dos_tick_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (load),
    .en_i    (phase != PH_IDLE),
    .tick_i  (tick_i),
    .limit_i (limit),
    .done_o  (done)
  );

  dos_phase_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .rise_i  (rise),
    .done_i  (done),
    .phase_o (phase),
    .load_o  (load),
    .pulse_o (pulse_o),
    .busy_o  (busy_o)
  );

endmodule

// File: rtl/delayed_oneshot_chk.sv
module delayed_oneshot_chk (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic trig_i,
  input logic pulse_o,
  input logic busy_o
);

  p_pulse_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> busy_o);

  p_pulse_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(pulse_o));

  p_start_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && trig_i && !$past(trig_i) && !$past(rst)) |=> busy_o);

  p_no_level_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !(trig_i && !$past(trig_i) && !$past(rst))) |=> !busy_o);

  p_end_together_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> $fell(busy_o));

  p_wait_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !pulse_o) |=> busy_o);

endmodule

bind delayed_oneshot delayed_oneshot_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .tick_i  (tick_i),
  .trig_i  (trig_i),
  .pulse_o (pulse_o),
  .busy_o  (busy_o)
);

// File: tb/delayed_oneshot_tb_top.sv
`timescale 1ns/1ps
module delayed_oneshot_tb_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_i = 1'b0;
  logic          trig_i = 1'b0;
  logic [CW-1:0] delay_len_i = '0;
  logic [CW-1:0] pulse_len_i = '0;
  logic          pulse_o;
  logic          busy_o;

  always #2.5 clk = ~clk;

  delayed_oneshot #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .trig_i(trig_i),
    .delay_len_i(delay_len_i), .pulse_len_i(pulse_len_i),
    .pulse_o(pulse_o), .busy_o(busy_o)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done_flag = 0;

  // Reference model: counts remaining ticks down (R2..R10)
  bit m_busy, m_pulse, m_prev, m_rise;
  int m_rem, m_plen;

  function automatic int at_least_one(int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_pulse = 0; m_prev = 1; m_rem = 0; m_plen = 1;
    end else begin
      m_rise = trig_i && !m_prev;
      m_prev = trig_i;
      if (!m_busy) begin
        if (m_rise) begin
          m_busy = 1;
          m_rem  = at_least_one(int'(delay_len_i));
          m_plen = at_least_one(int'(pulse_len_i));
        end
      end else if (tick_i) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          if (!m_pulse) begin m_pulse = 1; m_rem = m_plen; end
          else          begin m_pulse = 0; m_busy = 0; end
        end
      end
    end
  end

  task automatic check_bit(string tag, string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // tick spacing: 0 = random, k = one tick every k clocks
  int tper = 1;
  int tcnt = 0;
  task automatic next_tick(output bit k);
    if (tper == 0) k = 1'($urandom_range(0, 1));
    else begin
      tcnt++;
      k = (tcnt % tper) == 0;
    end
  endtask

  task automatic cyc(bit t, bit k);
    trig_i = t;
    tick_i = k;
    @(posedge clk);
    #1;
    check_bit(cur_req, "pulse_o", pulse_o, m_pulse);
    check_bit(cur_req, "busy_o", busy_o, m_busy);
  endtask

  task automatic cyc_auto(bit t);
    bit k;
    next_tick(k);
    cyc(t, k);
  endtask

  task automatic start_cycle(int d, int p);
    delay_len_i = CW'(d);
    pulse_len_i = CW'(p);
    cyc_auto(0);
    cyc_auto(1);
  endtask

  // tmode: 0 trigger low, 1 trigger high, 2 random trigger
  task automatic run_to_idle(int tmode);
    for (int i = 0; i < 20000 && m_busy; i++) begin
      if (tmode == 2) cyc_auto(1'($urandom_range(0, 1)));
      else            cyc_auto(tmode == 1);
    end
  endtask

  initial begin
    void'($urandom(32'h1d3a));
    // R1: reset with trigger already high
    trig_i = 1;
    repeat (4) @(posedge clk);
    #1;
    check_bit("R1", "pulse_o in reset", pulse_o, 1'b0);
    check_bit("R1", "busy_o in reset", busy_o, 1'b0);
    rst = 0;
    for (int i = 0; i < 12; i++) cyc(1, 1);
    check_bit("R1", "busy_o with level high", busy_o, 1'b0);

    // R2/R4/R5: clean edge, tick every clock
    cur_req = "R4"; tper = 1;
    start_cycle(3, 2);
    check_bit("R2", "busy_o after edge", busy_o, 1'b1);
    run_to_idle(0);
    check_bit("R5", "busy_o after pulse", busy_o, 1'b0);

    // R4/R5: sparse ticks
    cur_req = "R5"; tper = 3;
    start_cycle(5, 4); run_to_idle(0);
    tper = 0;
    start_cycle(4, 3); run_to_idle(0);

    // R6: trigger toggles at random during cycles
    cur_req = "R6"; tper = 2;
    for (int n = 0; n < 6; n++) begin
      start_cycle(int'($urandom_range(1, 6)), int'($urandom_range(1, 6)));
      run_to_idle(2);
    end

    // R8: lengths changed mid-cycle, then used next cycle
    cur_req = "R8"; tper = 1;
    start_cycle(4, 3);
    cyc_auto(0);
    delay_len_i = CW'(9); pulse_len_i = CW'(7);
    run_to_idle(0);
    start_cycle(9, 7); run_to_idle(0);

    // R9: zero lengths
    cur_req = "R9";
    start_cycle(0, 0);
    cyc(0, 1);
    check_bit("R9", "pulse_o after one tick", pulse_o, 1'b1);
    cyc(0, 1);
    check_bit("R9", "busy_o after one-tick pulse", busy_o, 1'b0);
    tper = 3; start_cycle(0, 2); run_to_idle(0);

    // R7: edge on the ending clock edge
    cur_req = "R7"; tper = 1;
    start_cycle(2, 2);
    while (!(m_pulse && m_rem == 1)) cyc(0, 1);
    cyc(1, 1);
    check_bit("R7", "busy_o after coinciding edge", busy_o, 1'b0);
    for (int i = 0; i < 6; i++) cyc(1, 1);
    check_bit("R7", "busy_o while level stays high", busy_o, 1'b0);

    // R3: trigger held high through and past a cycle
    cur_req = "R3";
    start_cycle(3, 3);
    run_to_idle(1);
    for (int i = 0; i < 20; i++) cyc(1, 1);
    check_bit("R3", "busy_o after held trigger", busy_o, 1'b0);

    // R10: random mixture
    cur_req = "R10";
    for (int n = 0; n < 150; n++) begin
      tper = int'($urandom_range(0, 3));
      start_cycle(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
      run_to_idle(int'($urandom_range(0, 2)));
      for (int i = 0; i < int'($urandom_range(0, 3)); i++)
        cyc_auto(1'($urandom_range(0, 1)));
    end

    // R4/R5: full-length setting, tick every clock
    cur_req = "R4"; tper = 1;
    start_cycle(500, 100);
    run_to_idle(0);
    check_bit("R5", "busy_o after long cycle", busy_o, 1'b0);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule